// File: doc/BRIEF.md
# Board Interrupt Expander Register Block

This block gathers up to sixteen board-level interrupt request lines and merges them into a single active-low, level-signalled interrupt for a host processor. Each request line is brought into the block clock domain through a synchroniser. A rising level on a line latches a sticky pending bit. A per-line mask decides which pending bits may drive the merged output. The output stays low for as long as any pending bit that is not masked remains set.

The host reaches the block through a simple synchronous register bus of 16-bit halfwords inside a 4 KB window. To find which lines need service, the host reads the pending register. To retire a line, it writes a one to that line's bit in the clear register and then writes a zero. The clear register holds the pending bit at zero for as long as the one stays in place, so a line can only latch again once the zero has been written. Two constant identification words let the host confirm that the board is fitted, and a read-only word reports the revision of the logic.

Top module: `irq_fanin_regs`

## Requirements
- R1: After reset the mask register reads 0xFFFF, the pending register reads 0x0000, the clear register reads 0x0000, and `irqN` is high.
- R2: A request line passes through two synchroniser flops. Its rising level sets the pending bit on the third rising clock edge after the input changes. A single-cycle pulse is also latched. A line that stays high does not set its bit again once the bit has been cleared.
- R3: A pending bit is set by its line's rising level whatever the mask holds.
- R4: `irqN` is a registered output. It is low exactly when the previous cycle had at least one bit set in both the pending register and the inverted mask (mask bit 1 = line disabled). A pending bit is therefore seen on `irqN` one edge after it is set. Dropping the request line leaves `irqN` low.
- R5: While bit n of the clear register (offset 0x30) is 1, pending bit n is forced to 0 from the next edge on, and rising edges on line n are lost. Once a 0 is written to that bit, line n can latch again.
- R6: Writing 0xFFFF and then 0x0000 to the clear register empties every pending bit.
- R7: The identification registers at offsets 0x40 and 0x48 always read 0xAAAA and 0x5555.
- R8: The version register at offset 0x50 reads the `VERSION` parameter, which defaults to 0x0A03.
- R9: Writes to the pending, identification and version registers have no effect.
- R10: The pending register sits at offset 0x28 and the mask register at offset 0x38; the mask reads back what was written; bit n belongs to request line n. Read data appears on `busRdata` after the clock edge that samples the read.
- R11: A read of an address that has no register returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC (16) | Asynchronous board interrupt request lines, bit n = line n |
| busSel | input | 1 | Bus access strobe for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (12) | Byte address within the 4 KB window |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| irqN | output | 1 | Merged interrupt, active low, level |

## Verification
Results arrive at fixed times. A change on a request line reaches the pending register on the third rising edge and `irqN` on the fourth. A register write takes effect on its own edge, and a clear acts on the pending register one edge after that. Read data appears on the edge that samples the read. The bench drives every input on the falling edge and samples on falling edges counted from each stimulus. It probes `irqN` one cycle before a change is due as well as on the due cycle, so a pipeline that is a stage too short or too long is reported.

// File: rtl/irq_fanin_pkg.sv
package irq_fanin_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_MASK,
    RD_CLEAR,
    RD_IDA,
    RD_IDB,
    RD_VER
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrClear;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl
  import irq_fanin_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int OFF_STATUS = 'h28,
  parameter int OFF_CLEAR  = 'h30,
  parameter int OFF_MASK   = 'h38,
  parameter int OFF_IDA    = 'h40,
  parameter int OFF_IDB    = 'h48,
  parameter int OFF_VER    = 'h50
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_IDA    = ADDR_W'(OFF_IDA);
  localparam logic [ADDR_W-1:0] A_IDB    = ADDR_W'(OFF_IDB);
  localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(OFF_VER);

  logic hitStatus, hitClear, hitMask, hitIdA, hitIdB, hitVer;
  logic doWrite, doRead;

  assign hitStatus = (busAddr == A_STATUS);
  assign hitClear  = (busAddr == A_CLEAR);
  assign hitMask   = (busAddr == A_MASK);
  assign hitIdA    = (busAddr == A_IDA);
  assign hitIdB    = (busAddr == A_IDB);
  assign hitVer    = (busAddr == A_VER);

  assign doWrite = busSel && busWr;
  assign doRead  = busSel && !busWr;

  // Only the mask and clear registers accept writes; other hits are dropped.
  always_comb begin
    strb.wrMask  = doWrite && hitMask;
    strb.wrClear = doWrite && hitClear;
    strb.rdEn    = doRead;
    if (hitStatus)      strb.rdSel = RD_STATUS;
    else if (hitMask)   strb.rdSel = RD_MASK;
    else if (hitClear)  strb.rdSel = RD_CLEAR;
    else if (hitIdA)    strb.rdSel = RD_IDA;
    else if (hitIdB)    strb.rdSel = RD_IDB;
    else if (hitVer)    strb.rdSel = RD_VER;
    else                strb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/irq_fanin_dp.sv
module irq_fanin_dp
  import irq_fanin_pkg::*;
#(
  parameter int          NUM_SRC     = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] ID_A        = 16'hAAAA,
  parameter logic [15:0] ID_B        = 16'h5555,
  parameter logic [15:0] VERSION     = 16'h0A03
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqN
);

  // Stage SYNC_STAGES is the previous-value flop used for edge detection.
  logic [NUM_SRC-1:0] syncStage [SYNC_STAGES+1];
  logic [NUM_SRC-1:0] riseVec;
  logic [NUM_SRC-1:0] statusQ;
  logic [DATA_W-1:0]  maskQ;
  logic [DATA_W-1:0]  clearQ;
  logic [NUM_SRC-1:0] activeVec;
  logic               irqNQ;
  logic [DATA_W-1:0]  rdataQ;
  logic [DATA_W-1:0]  rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncStage[0] <= '0;
    else       syncStage[0] <= srcIn;
  end

  for (genvar s = 1; s <= SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= '0;
      else       syncStage[s] <= syncStage[s-1];
    end
  end

  assign riseVec = syncStage[SYNC_STAGES-1] & ~syncStage[SYNC_STAGES];

  // Pending bits: set on a rising level, held clear while the clear bit is 1.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ | riseVec) & ~clearQ[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '1;
    else if (strb.wrMask) maskQ <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             clearQ <= '0;
    else if (strb.wrClear) clearQ <= busWdata;
  end

  assign activeVec = statusQ & ~maskQ[NUM_SRC-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqNQ <= 1'b1;
    else       irqNQ <= ~(|activeVec);
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_STATUS: rdNext = DATA_W'(statusQ);
      RD_MASK:   rdNext = maskQ;
      RD_CLEAR:  rdNext = clearQ;
      RD_IDA:    rdNext = ID_A;
      RD_IDB:    rdNext = ID_B;
      RD_VER:    rdNext = VERSION;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdataQ <= '0;
    else if (strb.rdEn) rdataQ <= rdNext;
  end

  assign busRdata = rdataQ;
  assign irqN     = irqNQ;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(clearQ[NUM_SRC-1:0])) == '0)); // R5

  AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusQ) & ~statusQ & ~$past(clearQ[NUM_SRC-1:0])) == '0)); // R2

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqN == !(|($past(statusQ) & ~$past(maskQ[NUM_SRC-1:0]))))); // R4

  AST_IDA_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == RD_IDA) |=> (busRdata == ID_A)); // R7

  AST_IDB_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == RD_IDB) |=> (busRdata == ID_B)); // R7

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMask |=> (maskQ == $past(busWdata))); // R10

endmodule

// File: rtl/irq_fanin_regs.sv
module irq_fanin_regs
  import irq_fanin_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          NUM_SRC     = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VERSION     = 16'h0A03
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [15:0]        busWdata,
  output logic [15:0]        busRdata,
  output logic               irqN
);

  strobe_t strb;

  irq_fanin_ctrl #(
    .ADDR_W (ADDR_W)
  ) uCtrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  irq_fanin_dp #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES),
    .VERSION     (VERSION)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqN     (irqN)
  );

endmodule

// File: tb/irq_fanin_regs_test.sv
module irq_fanin_regs_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] srcIn;
  logic        busSel, busWr;
  logic [11:0] busAddr;
  logic [15:0] busWdata;
  logic [15:0] busRdata;
  logic        irqN;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  localparam logic [11:0] A_STATUS = 12'h028;
  localparam logic [11:0] A_CLEAR  = 12'h030;
  localparam logic [11:0] A_MASK   = 12'h038;
  localparam logic [11:0] A_IDA    = 12'h040;
  localparam logic [11:0] A_IDB    = 12'h048;
  localparam logic [11:0] A_VER    = 12'h050;

  always #10 clk = ~clk;

  irq_fanin_regs uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqN(irqN)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(logic [11:0] a, logic [15:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [15:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic expectReg(string req, logic [11:0] a, logic [15:0] exp);
    logic [15:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    check("R1 irqN", {15'd0, irqN}, 16'h0001);
    expectReg("R1 mask", A_MASK, 16'hFFFF);
    expectReg("R1 pending", A_STATUS, 16'h0000);
    expectReg("R1 clear", A_CLEAR, 16'h0000);
  endtask

  task automatic t_ident();
    expectReg("R7 idA", A_IDA, 16'hAAAA);
    expectReg("R7 idB", A_IDB, 16'h5555);
    expectReg("R8 version", A_VER, 16'h0A03);
    expectReg("R11 unmapped", 12'h100, 16'h0000);
    expectReg("R11 odd address", 12'h029, 16'h0000);
  endtask

  task automatic t_readOnly();
    busWrite(A_STATUS, 16'hFFFF);
    busWrite(A_IDA, 16'h1234);
    busWrite(A_VER, 16'h0000);
    tick(1);
    expectReg("R9 pending write", A_STATUS, 16'h0000);
    expectReg("R9 idA write", A_IDA, 16'hAAAA);
    expectReg("R9 version write", A_VER, 16'h0A03);
    check("R9 irqN", {15'd0, irqN}, 16'h0001);
  endtask

  task automatic t_maskedLatch();
    srcIn[3] = 1'b1;
    tick(5);
    check("R4 masked irqN", {15'd0, irqN}, 16'h0001);
    expectReg("R3 pending while masked", A_STATUS, 16'h0008);
    busWrite(A_MASK, 16'hFFF7);
    tick(1);
    check("R4 unmask irqN", {15'd0, irqN}, 16'h0000);
    expectReg("R10 mask readback", A_MASK, 16'hFFF7);
  endtask

  task automatic t_clearRearm();
    busWrite(A_CLEAR, 16'h0008);
    tick(1);
    expectReg("R5 cleared", A_STATUS, 16'h0000);
    check("R5 irqN released", {15'd0, irqN}, 16'h0001);
    busWrite(A_CLEAR, 16'h0000);
    tick(4);
    expectReg("R2 held level no reset", A_STATUS, 16'h0000);
    srcIn[3] = 1'b0;
    tick(3);
    srcIn[3] = 1'b1;
    tick(3);
    expectReg("R5 rearmed", A_STATUS, 16'h0008);
    check("R4 irqN again", {15'd0, irqN}, 16'h0000);
    srcIn[3] = 1'b0;
    busWrite(A_CLEAR, 16'h0008);
    busWrite(A_CLEAR, 16'h0000);
    tick(2);
  endtask

  task automatic t_clearHold();
    busWrite(A_CLEAR, 16'h0010);
    srcIn[4] = 1'b1;
    tick(2);
    srcIn[4] = 1'b0;
    tick(4);
    expectReg("R5 edge lost while held", A_STATUS, 16'h0000);
    busWrite(A_CLEAR, 16'h0000);
    tick(2);
    expectReg("R5 no late latch", A_STATUS, 16'h0000);
  endtask

  task automatic t_latency();
    busWrite(A_MASK, 16'hFFE0);
    srcIn[0] = 1'b1;
    tick(3);
    check("R4 irqN one edge after pending", {15'd0, irqN}, 16'h0001);
    tick(1);
    check("R2 R4 irqN on fourth edge", {15'd0, irqN}, 16'h0000);
    srcIn[1] = 1'b1;
    tick(1);
    srcIn[1] = 1'b0;
    srcIn[0] = 1'b0;
    tick(4);
    expectReg("R2 pulse latched", A_STATUS, 16'h0003);
    check("R4 level held after line drops", {15'd0, irqN}, 16'h0000);
    busWrite(A_MASK, 16'hFFE3);
    tick(1);
    check("R4 masked again", {15'd0, irqN}, 16'h0001);
    expectReg("R4 mask keeps pending", A_STATUS, 16'h0003);
  endtask

  task automatic t_clearAll();
    srcIn[15] = 1'b1;
    srcIn[9]  = 1'b1;
    tick(4);
    expectReg("R10 bit n is line n", A_STATUS, 16'h8203);
    busWrite(A_CLEAR, 16'hFFFF);
    busWrite(A_CLEAR, 16'h0000);
    tick(1);
    expectReg("R6 all cleared", A_STATUS, 16'h0000);
    expectReg("R6 clear reg back to zero", A_CLEAR, 16'h0000);
    srcIn = '0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      nBad++;
      nVec++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; srcIn = '0; busSel = 1'b0; busWr = 1'b0;
    busAddr = '0; busWdata = '0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_ident();
    t_readOnly();
    t_maskedLatch();
    t_clearRearm();
    t_clearHold();
    t_latency();
    t_clearAll();
    done = 1;
    finishRun();
  end

endmodule